// File: doc/BRIEF.md
# Dual-Channel Charge Sequencer

Two battery channels share a single charge slot. The slot carries either the high-current fast-charge phase or the reduced-rate top-off phase. This sequencer decides which channel holds the slot. It also decides in what order the phases after fast charge run across both channels. It tracks every channel through these stages:

- idle
- discharging
- waiting for fast charge
- fast charging
- waiting for top-off
- topping off
- maintenance

It sees only pulses and levels from the per-channel charge controllers: presence, cycle start, fast-charge finished, top-off finished, discharge finished and the top-off enable. It answers with one-hot grants for each channel.

Channel index 0 is channel A and index 1 is channel B. The higher index has priority when the slot is free. A fast-charge grant is never taken away while the pack stays present. Top-off starts only once no channel is discharging or waiting for fast charge, and then runs on B before A. A new cycle started on B ends an ongoing top-off on A. Maintenance grants are given to every present channel that has finished, whatever the slot is doing.

Top module: `charge_slot_seq`

## Requirements
- R1: While reset is high, and on the cycle after it, every fast, top-off and maintenance grant is low.
- R2: At most one channel holds a fast or top-off grant in any cycle, and active_o marks exactly that channel.
- R3: When both packs are present and start a cycle in the same clock with the slot free, B holds fast charge on the next cycle. When B then reports fast done, A holds fast charge on the next cycle.
- R4: A channel holding fast charge keeps it until it reports fast done or loses its pack; a cycle start on the other channel does not move the grant.
- R5: Top-off is granted only when no channel is discharging or waiting for fast charge; among waiting channels B is topped off before A.
- R6: With top_en_i low, a fast-done pulse moves the channel directly to maintenance.
- R7: A cycle start on present B while A holds top-off ends A's top-off and moves A to maintenance on the next cycle; B holds fast charge on that same cycle.
- R8: A cycle start on A with the discharge-first flag set holds A without a grant until A's discharge-done pulse. This may happen while B holds the slot. After the pulse A waits until the slot is free. The discharge-first flag on B has no effect.
- R9: Every present channel that has finished its fast and top-off phases holds a maintenance grant, also while the other channel holds the slot.
- R10: A channel whose presence input is low has all grants low on the next cycle; a channel waiting for the slot takes it on that same cycle.
- R11: Cycle-start pulses on an absent channel and done pulses on a channel not in the matching phase change no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| present_i | input | NCH | Pack present level per channel |
| cycle_start_i | input | NCH | New charge cycle pulse per channel |
| dis_first_i | input | NCH | With a cycle start, discharge before charging (discharge-capable channels only) |
| fast_done_i | input | NCH | Fast charge terminated pulse per channel |
| top_done_i | input | NCH | Top-off finished pulse per channel |
| dis_done_i | input | NCH | Discharge finished pulse per channel |
| top_en_i | input | 1 | Top-off phase enabled |
| fast_grant_o | output | NCH | Fast-charge grant per channel |
| top_grant_o | output | NCH | Top-off grant per channel |
| maint_grant_o | output | NCH | Maintenance charge grant per channel |
| active_o | output | NCH | Channel currently holding the slot |

## Verification
The assertions check on every cycle the properties that depend only on grants and inputs:
- slot exclusivity;
- that a held fast grant cannot be preempted;
- that grants are released when a pack is removed;
- that B's cycle start ends A's top-off;
- that B wins a common start;
- that grants are clear after reset.

The order of top-off after both fast charges, the blocking of top-off by a discharging channel, the discharge hold on A and the effect of the enable flag need multi-step histories. Only the directed scenarios and the randomized comparison against the bench's reference model can show these.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DISCH   = 3'd1,
        ST_WAIT_FC = 3'd2,
        ST_FC      = 3'd3,
        ST_WAIT_TO = 3'd4,
        ST_TO      = 3'd5,
        ST_MAINT   = 3'd6
    } ch_state_e;

    function automatic logic holds_slot(ch_state_e s);
        return (s == ST_FC) || (s == ST_TO);
    endfunction

endpackage

// File: rtl/ch_track.sv
module ch_track
    import seq_pkg::*;
#(
    parameter bit CAN_DISCH = 1'b0
) (
    input  ch_state_e state_q_i,
    input  logic      present_i,
    input  logic      start_i,
    input  logic      dis_first_i,
    input  logic      fast_done_i,
    input  logic      top_done_i,
    input  logic      dis_done_i,
    input  logic      top_en_i,
    input  logic      abort_top_i,
    output ch_state_e state_o
);

    logic want_dis;
    logic dis_end;

    assign want_dis = CAN_DISCH && dis_first_i;
    assign dis_end  = CAN_DISCH && dis_done_i;

    always_comb begin
        state_o = state_q_i;
        if (!present_i) begin
            state_o = ST_IDLE;
        end else if (start_i) begin
            state_o = want_dis ? ST_DISCH : ST_WAIT_FC;
        end else begin
            case (state_q_i)
                ST_DISCH: begin
                    if (dis_end) state_o = ST_WAIT_FC;
                end
                ST_FC: begin
                    if (fast_done_i) state_o = top_en_i ? ST_WAIT_TO : ST_MAINT;
                end
                ST_TO: begin
                    if (top_done_i || abort_top_i) state_o = ST_MAINT;
                end
                default: state_o = state_q_i;
            endcase
        end
    end

endmodule

// File: rtl/slot_arb.sv
module slot_arb
    import seq_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  ch_state_e [NCH-1:0] pre_i,
    output logic                win_v_o,
    output logic [IDXW-1:0]     win_idx_o,
    output logic                win_top_o
);

    logic            busy;
    logic            fc_v;
    logic            to_v;
    logic            to_block;
    logic [IDXW-1:0] fc_idx;
    logic [IDXW-1:0] to_idx;

    always_comb begin
        busy     = 1'b0;
        fc_v     = 1'b0;
        to_v     = 1'b0;
        to_block = 1'b0;
        fc_idx   = '0;
        to_idx   = '0;
        // ascending scan: the highest index found last wins
        for (int c = 0; c < NCH; c++) begin
            if (holds_slot(pre_i[c])) busy = 1'b1;
            if (pre_i[c] == ST_DISCH || pre_i[c] == ST_WAIT_FC) to_block = 1'b1;
            if (pre_i[c] == ST_WAIT_FC) begin
                fc_v   = 1'b1;
                fc_idx = IDXW'(c);
            end
            if (pre_i[c] == ST_WAIT_TO) begin
                to_v   = 1'b1;
                to_idx = IDXW'(c);
            end
        end
        win_v_o   = 1'b0;
        win_idx_o = '0;
        win_top_o = 1'b0;
        if (!busy) begin
            if (fc_v) begin
                win_v_o   = 1'b1;
                win_idx_o = fc_idx;
            end else if (to_v && !to_block) begin
                win_v_o   = 1'b1;
                win_idx_o = to_idx;
                win_top_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/charge_slot_seq.sv
module charge_slot_seq
    import seq_pkg::*;
#(
    parameter int             NCH        = 2,
    parameter logic [NCH-1:0] DISCH_MASK = 1
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [NCH-1:0] present_i,
    input  logic [NCH-1:0] cycle_start_i,
    input  logic [NCH-1:0] dis_first_i,
    input  logic [NCH-1:0] fast_done_i,
    input  logic [NCH-1:0] top_done_i,
    input  logic [NCH-1:0] dis_done_i,
    input  logic           top_en_i,
    output logic [NCH-1:0] fast_grant_o,
    output logic [NCH-1:0] top_grant_o,
    output logic [NCH-1:0] maint_grant_o,
    output logic [NCH-1:0] active_o
);

    localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        ch_state_e [NCH-1:0] st;
    } seq_reg_t;

    seq_reg_t            seq_d;
    seq_reg_t            seq_q;
    ch_state_e [NCH-1:0] pre;
    logic [NCH-1:0]      abort_top;
    logic                win_v;
    logic [IDXW-1:0]     win_idx;
    logic                win_top;

    // a cycle start on any higher-priority present channel cuts a top-off short
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            abort_top[c] = 1'b0;
            for (int k = c + 1; k < NCH; k++) begin
                abort_top[c] = abort_top[c] | (cycle_start_i[k] & present_i[k]);
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ch_track #(
            .CAN_DISCH (DISCH_MASK[c])
        ) u_track (
            .state_q_i   (seq_q.st[c]),
            .present_i   (present_i[c]),
            .start_i     (cycle_start_i[c]),
            .dis_first_i (dis_first_i[c]),
            .fast_done_i (fast_done_i[c]),
            .top_done_i  (top_done_i[c]),
            .dis_done_i  (dis_done_i[c]),
            .top_en_i    (top_en_i),
            .abort_top_i (abort_top[c]),
            .state_o     (pre[c])
        );

        assign fast_grant_o[c]  = (seq_q.st[c] == ST_FC);
        assign top_grant_o[c]   = (seq_q.st[c] == ST_TO);
        assign maint_grant_o[c] = (seq_q.st[c] == ST_MAINT);
        assign active_o[c]      = holds_slot(seq_q.st[c]);

        AST_FAST_NO_PREEMPT: assert property (@(posedge clk_i) disable iff (rst_i)
            fast_grant_o[c] && present_i[c] && !fast_done_i[c] && !cycle_start_i[c]
            |=> fast_grant_o[c]); // R4

        AST_REMOVE_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
            !present_i[c] |=> !fast_grant_o[c] && !top_grant_o[c] && !maint_grant_o[c]); // R10
    end

    slot_arb #(
        .NCH  (NCH),
        .IDXW (IDXW)
    ) u_arb (
        .pre_i     (pre),
        .win_v_o   (win_v),
        .win_idx_o (win_idx),
        .win_top_o (win_top)
    );

    always_comb begin
        seq_d = seq_q;
        for (int c = 0; c < NCH; c++) begin
            seq_d.st[c] = pre[c];
        end
        if (win_v) begin
            seq_d.st[win_idx] = win_top ? ST_TO : ST_FC;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int c = 0; c < NCH; c++) begin
                seq_q.st[c] <= ST_IDLE;
            end
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_SLOT_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(fast_grant_o | top_grant_o)); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (fast_grant_o == '0) && (top_grant_o == '0) && (maint_grant_o == '0)); // R1

    AST_COMMON_START: assert property (@(posedge clk_i) disable iff (rst_i)
        ((fast_grant_o | top_grant_o) == '0) && (&present_i) && (&cycle_start_i)
        |=> fast_grant_o[NCH-1]); // R3

    if (NCH > 1) begin : g_abort_chk
        AST_B_ABORTS_TOP: assert property (@(posedge clk_i) disable iff (rst_i)
            cycle_start_i[NCH-1] && present_i[NCH-1] && top_grant_o[0]
            |=> !top_grant_o[0]); // R7
    end

endmodule

// File: tb/sim_charge_slot_seq.sv
`timescale 1ns/1ps
module sim_charge_slot_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pres = 2'b00, start = 2'b00, disf = 2'b00;
    logic [1:0] fd = 2'b00, td = 2'b00, dd = 2'b00;
    logic       ten = 1'b1;
    logic [1:0] fast, top, maint, act;

    int checks = 0;
    int failures = 0;
    int ms [2];   // 0 idle 1 disch 2 wait-fast 3 fast 4 wait-top 5 top 6 maint

    always #2.5 clk = ~clk;

    charge_slot_seq u0 (
        .clk_i (clk), .rst_i (rst), .present_i (pres), .cycle_start_i (start),
        .dis_first_i (disf), .fast_done_i (fd), .top_done_i (td), .dis_done_i (dd),
        .top_en_i (ten), .fast_grant_o (fast), .top_grant_o (top),
        .maint_grant_o (maint), .active_o (act)
    );

    function automatic logic [1:0] model_vec(int code);
        logic [1:0] v;
        for (int c = 0; c < 2; c++) v[c] = (ms[c] == code);
        return v;
    endfunction

    task automatic model_update();
        int nx [2];
        bit busy, block;
        if (rst) begin
            ms[0] = 0; ms[1] = 0;
            return;
        end
        for (int c = 0; c < 2; c++) begin
            nx[c] = ms[c];
            if (!pres[c]) nx[c] = 0;
            else if (start[c]) nx[c] = (c == 0 && disf[0]) ? 1 : 2;
            else if (ms[c] == 1 && c == 0 && dd[0]) nx[c] = 2;
            else if (ms[c] == 3 && fd[c]) nx[c] = ten ? 4 : 6;
            else if (ms[c] == 5 && (td[c] || (c == 0 && start[1] && pres[1]))) nx[c] = 6;
        end
        busy  = (nx[0] == 3 || nx[0] == 5 || nx[1] == 3 || nx[1] == 5);
        block = (nx[0] == 1 || nx[0] == 2 || nx[1] == 1 || nx[1] == 2);
        if (!busy) begin
            if (nx[1] == 2) nx[1] = 3;
            else if (nx[0] == 2) nx[0] = 3;
            else if (!block && nx[1] == 4) nx[1] = 5;
            else if (!block && nx[0] == 4) nx[0] = 5;
        end
        ms[0] = nx[0]; ms[1] = nx[1];
    endtask

    task automatic step();
        model_update();
        @(posedge clk);
        #1;
        start = 2'b00; fd = 2'b00; td = 2'b00; dd = 2'b00;
    endtask

    task automatic expect3(logic [1:0] ef, logic [1:0] et, logic [1:0] em, string req);
        checks++;
        if (fast !== ef || top !== et || maint !== em || act !== (ef | et)) begin
            failures++;
            $display("FAIL %s: fast=%b top=%b maint=%b act=%b expected fast=%b top=%b maint=%b",
                     req, fast, top, maint, act, ef, et, em);
        end
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1;
        step(); step();
        expect3(2'b00, 2'b00, 2'b00, "R1 during reset");
        rst = 1'b0;
        expect3(2'b00, 2'b00, 2'b00, "R1 after reset");

        // common start: B first
        pres = 2'b11; start = 2'b11; step();
        expect3(2'b10, 2'b00, 2'b00, "R3 common start");
        start = 2'b01; step();
        expect3(2'b10, 2'b00, 2'b00, "R4 no preemption");
        fd = 2'b10; step();
        expect3(2'b01, 2'b00, 2'b00, "R3 A follows B");
        fd = 2'b01; step();
        expect3(2'b00, 2'b10, 2'b00, "R5 B top-off first");
        td = 2'b10; step();
        expect3(2'b00, 2'b01, 2'b10, "R5 A top-off second");
        td = 2'b01; step();
        expect3(2'b00, 2'b00, 2'b11, "R9 both maintenance");
        fd = 2'b10; td = 2'b01; step();
        expect3(2'b00, 2'b00, 2'b11, "R11 stray done pulses");
        pres = 2'b10; step();
        expect3(2'b00, 2'b00, 2'b10, "R10 removal of A");
        start = 2'b01; step();
        expect3(2'b00, 2'b00, 2'b10, "R11 start on absent A");

        // A alone on the slot, then B insertion during A top-off
        pres = 2'b11; start = 2'b01; step();
        expect3(2'b01, 2'b00, 2'b10, "R9 maintenance beside fast");
        fd = 2'b01; step();
        expect3(2'b00, 2'b01, 2'b10, "R5 A top-off");
        start = 2'b10; step();
        expect3(2'b10, 2'b00, 2'b01, "R7 B aborts A top-off");
        ten = 1'b0; fd = 2'b10; step();
        expect3(2'b00, 2'b00, 2'b11, "R6 top-off disabled");
        ten = 1'b1;

        // discharge on A while B active
        disf = 2'b01; start = 2'b11; step();
        disf = 2'b00;
        expect3(2'b10, 2'b00, 2'b00, "R8 A discharging");
        dd = 2'b01; step();
        expect3(2'b10, 2'b00, 2'b00, "R8 A pending after discharge");
        fd = 2'b10; step();
        expect3(2'b01, 2'b00, 2'b00, "R8 A fast after B");
        fd = 2'b01; step();
        expect3(2'b00, 2'b10, 2'b00, "R5 B top after both fast");
        pres = 2'b01; step();
        expect3(2'b00, 2'b01, 2'b00, "R10 hand-off on removal");
        pres = 2'b11; disf = 2'b10; start = 2'b10; step();
        disf = 2'b00;
        expect3(2'b10, 2'b00, 2'b01, "R8 discharge flag ignored on B");
        disf = 2'b01; start = 2'b01; step();
        disf = 2'b00;
        expect3(2'b10, 2'b00, 2'b00, "R8 A discharge during B fast");
        fd = 2'b10; step();
        expect3(2'b00, 2'b00, 2'b00, "R5 top-off blocked by discharge");
        dd = 2'b01; step();
        expect3(2'b01, 2'b00, 2'b00, "R8 A fast after discharge");

        // randomized phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            for (int c = 0; c < 2; c++) begin
                if ($urandom_range(63) == 0) begin
                    pres[c] = ~pres[c];
                    if (pres[c]) start[c] = 1'b1;
                end
                if ($urandom_range(15) == 0) start[c] = 1'b1;
                fd[c] = ($urandom_range(7) == 0);
                td[c] = ($urandom_range(7) == 0);
                dd[c] = ($urandom_range(7) == 0);
                disf[c] = $urandom_range(1);
            end
            if ($urandom_range(31) == 0) ten = ~ten;
            step();
            expect3(model_vec(3), model_vec(5), model_vec(6), "R2 random vs model");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule